// File: doc/BRIEF.md
# Zoned Bandwidth Monitor

The block measures traffic on one bus port. Every cycle it may receive a byte total with a valid strobe. It adds these totals over a sampling window, and the window length is counted in ticks of a slow timer strobe (nominally a 19.2 MHz reference, delivered as a one-cycle pulse). The byte sum is scaled down to count units of 2^UNIT_LOG2 bytes and saturates at the 12-bit maximum. When the window closes, the block sorts the unit count into one of four zones using three programmable thresholds.

Each zone has an action field. That field can increment or clear any zone's 8-bit hit counter. Each zone also has a hit limit, which decides when the zone's interrupt status bit is set. The block keeps the largest count seen in each zone. A level interrupt is raised when any status bit is set whose enable bit is also set. Software programs and observes everything through a word-addressed register port with single-cycle writes and combinational reads.

Top module: `zone_bw_monitor`

## Requirements
- R1: While monitoring is enabled, the tick timer advances once per cycle with `sample_tick` high, and a window closes on the tick that brings the timer count to the window length. Input presented in the closing cycle belongs to the closing window, and the next window starts from zero. Cycles without a tick close nothing, but byte input is still accumulated in them.
- R2: The window count is the window's byte sum divided by 2^UNIT_LOG2. The byte sum saturates rather than wrapping, so the count stops at 4095.
- R3: The zone is chosen as follows: zone 3 if count >= high; else zone 2 if count >= medium; else zone 1 if count >= low; else zone 0. A count equal to a threshold therefore goes to the higher zone. Exactly one zone is chosen per window.
- R4: The action register (address 6) holds one byte per zone, with zone z at bits 8z+7..8z. This byte is applied when a window lands in zone z. Inside the byte, bit 2j+1 increments zone j's saturating hit counter and bit 2j clears it. If both bits are set, clear wins.
- R5: The hit-limit register (address 7) holds one byte per zone, with zone z at bits 8z+7..8z. When a window lands in zone z, status bit z is set if zone z's updated hit count is >= its limit. A limit of 0xFF never sets the status bit. Status bits change only when a window closes or on an interrupt-clear write.
- R6: The maximum register of zone z (addresses 11+z, bits 11:0) holds the largest count of any window that landed in zone z. Only a clear-all command lowers it.
- R7: Status (address 8) and interrupt enable (address 9) use bits 3:0, with bit z for zone z. Status is set whatever the enable bit holds. `irq` is high exactly when some status bit and its enable bit are both 1.
- R8: Writing the interrupt-clear register (address 10) drops every status bit written as 1. If a window sets the same bit in the same cycle, the bit stays set.
- R9: The clear register (address 1) behaves as follows. Bit 0 zeroes the byte sum, the tick timer and the hit counters. Bit 1 does the same and also zeroes all zone maxima. Neither bit changes status. Addresses 1 and 10 read as zero.
- R10: Bit 0 of address 0 enables monitoring. While it is 0, byte input, the timer, hit counters, maxima and status are all left untouched.
- R11: After reset, every register reads zero, monitoring is off and `irq` is low. The window length is at address 2, and the low, medium and high thresholds are at addresses 3, 4 and 5 (bits 11:0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sample_tick | input | 1 | One-cycle strobe per timer tick |
| in_valid | input | 1 | `in_bytes` carries a byte total this cycle |
| in_bytes | input | BYTE_W | Bytes transferred this cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Word address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| irq | output | 1 | Level interrupt |

## Verification
A window can close in the same cycle in which software writes the interrupt-clear register for the bit that window sets. The bench provokes this by issuing the clear write in the final cycle of a zone-2 window. It judges the result by reading status afterwards and expecting the bit to still be set. A clear command that arrives alongside a closing window is the second pairing. In that case the zone maxima must keep growing unless clear-all was written, and a checker property enforces this on every cycle.

// File: rtl/zbm_pkg.sv
package zbm_pkg;
  localparam int ZONES  = 4;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam int HIT_W  = 8;

  typedef logic [1:0] zone_t;

  typedef enum logic [ADDR_W-1:0] {
    A_ENABLE  = 4'd0,
    A_CLEAR   = 4'd1,
    A_WINDOW  = 4'd2,
    A_THR_LO  = 4'd3,
    A_THR_MED = 4'd4,
    A_THR_HI  = 4'd5,
    A_ACTIONS = 4'd6,
    A_HITLIM  = 4'd7,
    A_STATUS  = 4'd8,
    A_IRQ_EN  = 4'd9,
    A_IRQ_CLR = 4'd10,
    A_MAX0    = 4'd11,
    A_MAX1    = 4'd12,
    A_MAX2    = 4'd13,
    A_MAX3    = 4'd14
  } reg_addr_e;
endpackage

// File: rtl/zbm_window.sv
module zbm_window #(
  parameter int WIN_W     = 24,
  parameter int CNT_W     = 12,
  parameter int BYTE_W    = 16,
  parameter int UNIT_LOG2 = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              restart,
  input  logic              tick,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_bytes,
  input  logic [WIN_W-1:0]  win_len,
  output logic              win_end,
  output logic [CNT_W-1:0]  win_count
);
  localparam int ACC_W = CNT_W + UNIT_LOG2;
  localparam int SUM_W = ((ACC_W > BYTE_W) ? ACC_W : BYTE_W) + 1;

  logic [ACC_W-1:0] acc_q, acc_d, acc_sat;
  logic [SUM_W-1:0] sum;
  logic [WIN_W-1:0] tmr_q, tmr_d;
  logic [WIN_W:0]   tmr_next;
  logic             acc_en, tmr_en;

  always_comb begin
    sum      = SUM_W'(acc_q) + ((run && in_valid) ? SUM_W'(in_bytes) : '0);
    acc_sat  = (sum > SUM_W'({ACC_W{1'b1}})) ? {ACC_W{1'b1}} : sum[ACC_W-1:0];
    tmr_next = {1'b0, tmr_q} + (WIN_W+1)'(1);
    win_end  = run && tick && (tmr_next >= {1'b0, win_len});
    win_count = acc_sat[ACC_W-1:UNIT_LOG2];

    acc_en = restart | run;
    acc_d  = (restart || win_end) ? '0 : acc_sat;
    tmr_en = restart | (run & tick);
    tmr_d  = (restart || win_end) ? '0 : tmr_next[WIN_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      tmr_q <= '0;
    end else begin
      if (acc_en) acc_q <= acc_d;
      if (tmr_en) tmr_q <= tmr_d;
    end
  end
endmodule

// File: rtl/zbm_zone_engine.sv
module zbm_zone_engine
  import zbm_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        win_end,
  input  logic [CNT_W-1:0]            win_count,
  input  logic [CNT_W-1:0]            thr_lo,
  input  logic [CNT_W-1:0]            thr_med,
  input  logic [CNT_W-1:0]            thr_hi,
  input  logic [DATA_W-1:0]           actions,
  input  logic [DATA_W-1:0]           hit_lim,
  input  logic                        clr_hits,
  input  logic                        clr_max,
  input  logic [ZONES-1:0]            status_clr,
  output logic [ZONES-1:0]            status,
  output logic [ZONES-1:0][CNT_W-1:0] zone_max
);
  zone_t            zone;
  logic [HIT_W-1:0] act_f, lim_z;
  logic [HIT_W-1:0] hit_nx [ZONES];
  logic [ZONES-1:0] set_vec, status_d, status_q;
  logic             status_en;

  always_comb begin
    if (win_count >= thr_hi)       zone = 2'd3;
    else if (win_count >= thr_med) zone = 2'd2;
    else if (win_count >= thr_lo)  zone = 2'd1;
    else                           zone = 2'd0;
    act_f = actions[{zone, 3'b000} +: HIT_W];
    lim_z = hit_lim[{zone, 3'b000} +: HIT_W];
  end

  for (genvar j = 0; j < ZONES; j++) begin : g_zone
    logic [HIT_W-1:0] h_q, h_d;
    logic [CNT_W-1:0] m_q, m_d;
    logic             h_en, m_en;

    always_comb begin
      h_d = h_q;
      if (clr_hits)                                        h_d = '0;
      else if (win_end && act_f[2*j])                      h_d = '0;
      else if (win_end && act_f[2*j+1] && (h_q != '1))     h_d = h_q + 1'b1;
      h_en = clr_hits | win_end;

      m_d = m_q;
      if (clr_max)                                                m_d = '0;
      else if (win_end && (zone == zone_t'(j)) && (win_count > m_q)) m_d = win_count;
      m_en = clr_max | win_end;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        h_q <= '0;
        m_q <= '0;
      end else begin
        if (h_en) h_q <= h_d;
        if (m_en) m_q <= m_d;
      end
    end

    assign hit_nx[j]   = h_d;
    assign zone_max[j] = m_q;
  end

  always_comb begin
    set_vec = '0;
    if (win_end && (lim_z != '1) && (hit_nx[zone] >= lim_z)) set_vec[zone] = 1'b1;
    status_d  = (status_q & ~status_clr) | set_vec;
    status_en = win_end | (|status_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         status_q <= '0;
    else if (status_en) status_q <= status_d;
  end

  assign status = status_q;
endmodule

// File: rtl/zbm_regfile.sv
module zbm_regfile
  import zbm_pkg::*;
#(
  parameter int WIN_W = 24,
  parameter int CNT_W = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_wr,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [DATA_W-1:0]           reg_wdata,
  output logic [DATA_W-1:0]           reg_rdata,
  input  logic [ZONES-1:0]            status,
  input  logic [ZONES-1:0][CNT_W-1:0] zone_max,
  output logic                        run_en,
  output logic [WIN_W-1:0]            win_len,
  output logic [CNT_W-1:0]            thr_lo,
  output logic [CNT_W-1:0]            thr_med,
  output logic [CNT_W-1:0]            thr_hi,
  output logic [DATA_W-1:0]           actions,
  output logic [DATA_W-1:0]           hit_lim,
  output logic [ZONES-1:0]            irq_en,
  output logic                        clr_hits,
  output logic                        clr_max,
  output logic [ZONES-1:0]            status_clr
);
  logic we_en, we_win, we_lo, we_med, we_hi, we_act, we_lim, we_ien, we_clr, we_iclr;

  always_comb begin
    we_en   = reg_wr && (reg_addr == A_ENABLE);
    we_clr  = reg_wr && (reg_addr == A_CLEAR);
    we_win  = reg_wr && (reg_addr == A_WINDOW);
    we_lo   = reg_wr && (reg_addr == A_THR_LO);
    we_med  = reg_wr && (reg_addr == A_THR_MED);
    we_hi   = reg_wr && (reg_addr == A_THR_HI);
    we_act  = reg_wr && (reg_addr == A_ACTIONS);
    we_lim  = reg_wr && (reg_addr == A_HITLIM);
    we_ien  = reg_wr && (reg_addr == A_IRQ_EN);
    we_iclr = reg_wr && (reg_addr == A_IRQ_CLR);

    clr_hits   = we_clr && (reg_wdata[0] || reg_wdata[1]);
    clr_max    = we_clr && reg_wdata[1];
    status_clr = we_iclr ? reg_wdata[ZONES-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_en  <= 1'b0;
      win_len <= '0;
      thr_lo  <= '0;
      thr_med <= '0;
      thr_hi  <= '0;
      actions <= '0;
      hit_lim <= '0;
      irq_en  <= '0;
    end else begin
      if (we_en)  run_en  <= reg_wdata[0];
      if (we_win) win_len <= reg_wdata[WIN_W-1:0];
      if (we_lo)  thr_lo  <= reg_wdata[CNT_W-1:0];
      if (we_med) thr_med <= reg_wdata[CNT_W-1:0];
      if (we_hi)  thr_hi  <= reg_wdata[CNT_W-1:0];
      if (we_act) actions <= reg_wdata;
      if (we_lim) hit_lim <= reg_wdata;
      if (we_ien) irq_en  <= reg_wdata[ZONES-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_ENABLE:  reg_rdata = DATA_W'(run_en);
      A_WINDOW:  reg_rdata = DATA_W'(win_len);
      A_THR_LO:  reg_rdata = DATA_W'(thr_lo);
      A_THR_MED: reg_rdata = DATA_W'(thr_med);
      A_THR_HI:  reg_rdata = DATA_W'(thr_hi);
      A_ACTIONS: reg_rdata = actions;
      A_HITLIM:  reg_rdata = hit_lim;
      A_STATUS:  reg_rdata = DATA_W'(status);
      A_IRQ_EN:  reg_rdata = DATA_W'(irq_en);
      A_MAX0:    reg_rdata = DATA_W'(zone_max[0]);
      A_MAX1:    reg_rdata = DATA_W'(zone_max[1]);
      A_MAX2:    reg_rdata = DATA_W'(zone_max[2]);
      A_MAX3:    reg_rdata = DATA_W'(zone_max[3]);
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/zone_bw_monitor.sv
module zone_bw_monitor
  import zbm_pkg::*;
#(
  parameter int WIN_W     = 24,
  parameter int CNT_W     = 12,
  parameter int BYTE_W    = 16,
  parameter int UNIT_LOG2 = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_tick,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_bytes,
  input  logic              reg_wr,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq
);
  logic [1:0]                 rst_pipe;
  logic                       rst_n_s;
  logic                       run_en, clr_hits, clr_max, win_end;
  logic [WIN_W-1:0]           win_len;
  logic [CNT_W-1:0]           thr_lo, thr_med, thr_hi, win_count;
  logic [DATA_W-1:0]          actions, hit_lim;
  logic [ZONES-1:0]           irq_en, status, status_clr;
  logic [ZONES-1:0][CNT_W-1:0] zone_max;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  zbm_regfile #(.WIN_W(WIN_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n_s),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .status(status), .zone_max(zone_max),
    .run_en(run_en), .win_len(win_len),
    .thr_lo(thr_lo), .thr_med(thr_med), .thr_hi(thr_hi),
    .actions(actions), .hit_lim(hit_lim), .irq_en(irq_en),
    .clr_hits(clr_hits), .clr_max(clr_max), .status_clr(status_clr)
  );

  zbm_window #(.WIN_W(WIN_W), .CNT_W(CNT_W), .BYTE_W(BYTE_W), .UNIT_LOG2(UNIT_LOG2)) u_win (
    .clk(clk), .rst_n(rst_n_s),
    .run(run_en), .restart(clr_hits), .tick(sample_tick),
    .in_valid(in_valid), .in_bytes(in_bytes), .win_len(win_len),
    .win_end(win_end), .win_count(win_count)
  );

  zbm_zone_engine #(.CNT_W(CNT_W)) u_zone (
    .clk(clk), .rst_n(rst_n_s),
    .win_end(win_end), .win_count(win_count),
    .thr_lo(thr_lo), .thr_med(thr_med), .thr_hi(thr_hi),
    .actions(actions), .hit_lim(hit_lim),
    .clr_hits(clr_hits), .clr_max(clr_max), .status_clr(status_clr),
    .status(status), .zone_max(zone_max)
  );

  assign irq = |(status & irq_en);
endmodule

// File: rtl/zbm_checker.sv
module zbm_checker
  import zbm_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        reg_wr,
  input logic [3:0]                  reg_addr,
  input logic [31:0]                 reg_wdata,
  input logic                        run_en,
  input logic                        win_end,
  input logic [ZONES-1:0]            status,
  input logic [ZONES-1:0]            irq_en,
  input logic                        irq,
  input logic [ZONES-1:0][CNT_W-1:0] zone_max
);
  // R7: the interrupt line never rises with every enable bit clear
  p_irq_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en != '0));

  // R10: a disabled monitor raises no new status bit
  p_disabled_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> ((status & ~$past(status)) == '0));

  // R5: status bits appear only after a window close
  p_status_needs_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> ((status & ~$past(status)) == '0));

  // R3: one window selects one zone
  p_single_zone_r3: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> ($countones(status & ~$past(status)) <= 1));

  // R8: an interrupt-clear write without a window close drops the written bits
  p_irq_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_addr == A_IRQ_CLR) && !win_end) |=>
      ((status & $past(reg_wdata[ZONES-1:0])) == '0));

  // R6: maxima only fall on a clear-all command
  for (genvar j = 0; j < ZONES; j++) begin : g_max
    p_max_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && (reg_addr == A_CLEAR) && reg_wdata[1]) |=>
        (zone_max[j] >= $past(zone_max[j])));
  end
endmodule

bind zone_bw_monitor zbm_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n_s),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .run_en(run_en), .win_end(win_end), .status(status),
  .irq_en(irq_en), .irq(irq), .zone_max(zone_max)
);

// File: tb/zone_bw_monitor_tb.sv
module zone_bw_monitor_tb;
  localparam int ENABLE = 0, CLR = 1, WINDOW = 2, LO = 3, MED = 4, HI = 5;
  localparam int ACTS = 6, LIM = 7, STATUS = 8, IEN = 9, ICLR = 10, MAX0 = 11;
  localparam int ACT_DEF = 32'h8020_0802; // each zone increments its own counter
  localparam int NV = 8;
  // {bytes per cycle, expected zone, expected count}; 4 cycles x bytes / 4
  localparam int VEC [NV][3] = '{
    '{0, 0, 0}, '{9, 0, 9}, '{10, 1, 10}, '{99, 1, 99},
    '{100, 2, 100}, '{999, 2, 999}, '{1000, 3, 1000}, '{65535, 3, 4095}};

  logic        clk, rst_n, sample_tick, in_valid, reg_wr, irq;
  logic [15:0] in_bytes;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  int checks = 0, fails = 0, v;

  zone_bw_monitor #(.UNIT_LOG2(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .in_valid(in_valid),
    .in_bytes(in_bytes), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = d;
    @(posedge clk); #1 reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk); reg_addr = 4'(a); #1 d = int'(reg_rdata);
  endtask

  task automatic configure(input int lim, input int act, input int ien);
    wr(WINDOW, 4); wr(LO, 10); wr(MED, 100); wr(HI, 1000);
    wr(ACTS, act); wr(LIM, lim); wr(IEN, ien);
  endtask

  task automatic fresh();
    wr(CLR, 2); wr(ICLR, 15);
  endtask

  task automatic run_window(input int b, input int clr, input bit tk);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_bytes = b[15:0]; sample_tick = tk;
      if (i == 3 && clr != 0) begin
        reg_wr = 1'b1; reg_addr = 4'(ICLR); reg_wdata = clr;
      end else reg_wr = 1'b0;
    end
  endtask

  task automatic stop();
    @(negedge clk);
    in_valid = 1'b0; in_bytes = '0; sample_tick = 1'b1;
    reg_wr = 1'b1; reg_addr = 4'(ENABLE); reg_wdata = 0;
    @(posedge clk); #1 reg_wr = 1'b0;
  endtask

  task automatic peek(output int d);
    @(posedge clk); #1 d = int'(reg_rdata);
  endtask

  initial begin
    #(20 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    clk = 0; rst_n = 0; sample_tick = 1; in_valid = 0; in_bytes = '0;
    reg_wr = 0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);

    // R11 reset state
    rd(STATUS, v); chk("R11 status", v, 0);
    chk("R11 irq", int'(irq), 0);
    rd(ENABLE, v); chk("R11 enable", v, 0);
    rd(WINDOW, v); chk("R11 window", v, 0);
    rd(MAX0 + 3, v); chk("R11 max3", v, 0);
    // R9 write-only registers
    wr(CLR, 3); rd(CLR, v); chk("R9 clear reads zero", v, 0);
    rd(ICLR, v); chk("R9 irq clear reads zero", v, 0);

    // vector table: R2 scaling/saturation, R3 zone choice, R6 maxima, R7 irq
    configure(0, ACT_DEF, 15);
    for (int k = 0; k < NV; k++) begin
      fresh(); wr(ENABLE, 1);
      run_window(VEC[k][0], 0, 1'b1);
      stop();
      rd(STATUS, v); chk($sformatf("R3 zone vec%0d", k), v, 1 << VEC[k][1]);
      rd(MAX0 + VEC[k][1], v); chk($sformatf("R2 count vec%0d", k), v, VEC[k][2]);
      chk($sformatf("R7 irq vec%0d", k), int'(irq), 1);
    end

    // R1 tickless cycles accumulate, window closes only after 4 ticks
    fresh(); wr(ENABLE, 1);
    run_window(50, 0, 1'b0);
    run_window(0, 0, 1'b1);
    stop();
    rd(STATUS, v); chk("R1 tick gating status", v, 2);
    rd(MAX0 + 1, v); chk("R1 tick gating count", v, 50);

    // R1 back-to-back windows restart from zero; R6 largest kept
    fresh(); wr(ENABLE, 1);
    run_window(2000, 0, 1'b1);
    run_window(3, 0, 1'b1);
    run_window(1500, 0, 1'b1);
    stop();
    rd(MAX0 + 3, v); chk("R6 max3 keeps largest", v, 2000);
    rd(MAX0, v); chk("R1 second window from zero", v, 3);
    rd(STATUS, v); chk("R1 status both zones", v, 9);

    // R5 hit limit 3 on zone 1
    configure(32'h0000_0300, ACT_DEF, 15);
    fresh(); wr(ENABLE, 1); reg_addr = 4'(STATUS);
    run_window(50, 0, 1'b1); run_window(50, 0, 1'b1);
    peek(v); chk("R5 below limit", v, 0);
    chk("R7 irq quiet below limit", int'(irq), 0);
    run_window(50, 0, 1'b1);
    peek(v); chk("R5 limit reached", v, 2);
    stop();

    // R5 limit 0xFF disables zone 3; R6 maximum still tracked
    configure(32'hFF00_0000, ACT_DEF, 15);
    fresh(); wr(ENABLE, 1);
    run_window(2000, 0, 1'b1);
    stop();
    rd(STATUS, v); chk("R5 0xFF never sets", v, 0);
    rd(MAX0 + 3, v); chk("R6 max with disabled zone", v, 2000);

    // R4 zone-0 action clears zone-1 hit counter
    configure(32'h0000_0200, 32'h8020_0806, 15);
    fresh(); wr(ENABLE, 1); reg_addr = 4'(STATUS);
    run_window(50, 0, 1'b1);
    run_window(5, 0, 1'b1);
    run_window(50, 0, 1'b1);
    peek(v); chk("R4 clear action reset count", v & 2, 0);
    run_window(50, 0, 1'b1);
    peek(v); chk("R4 count resumes", v & 2, 2);
    stop();

    // R7 status set while masked; R8 clear
    configure(0, ACT_DEF, 0);
    fresh(); wr(ENABLE, 1);
    run_window(500, 0, 1'b1);
    stop();
    rd(STATUS, v); chk("R7 masked status", v, 4);
    chk("R7 masked irq", int'(irq), 0);
    wr(IEN, 4); chk("R7 unmasked irq", int'(irq), 1);
    wr(ICLR, 4);
    rd(STATUS, v); chk("R8 clear drops bit", v, 0);
    chk("R8 irq after clear", int'(irq), 0);

    // R8 collision: clear of bit 2 in the closing cycle of a zone-2 window
    fresh(); wr(ENABLE, 1);
    run_window(500, 4, 1'b1);
    stop();
    rd(STATUS, v); chk("R8 set wins collision", v, 4);

    // R9 clear bits
    wr(CLR, 1);
    rd(MAX0 + 2, v); chk("R9 bit0 keeps max", v, 500);
    rd(STATUS, v); chk("R9 status untouched", v, 4);
    wr(CLR, 2);
    rd(MAX0 + 2, v); chk("R9 bit1 clears max", v, 0);

    // R10 disabled monitor ignores traffic
    fresh();
    run_window(500, 0, 1'b1); run_window(500, 0, 1'b1); run_window(500, 0, 1'b1);
    @(negedge clk); in_valid = 1'b0;
    rd(STATUS, v); chk("R10 no status when off", v, 0);
    rd(MAX0 + 2, v); chk("R10 no max when off", v, 0);
    wr(ENABLE, 1);
    run_window(20, 0, 1'b1);
    stop();
    rd(MAX0 + 1, v); chk("R10 nothing carried over", v, 20);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule